// File: doc/BRIEF.md
# Nibble-Bus Program ROM Slave

This block is a 256-byte read-only program store that sits on a shared 4-bit multiplexed bus. Each clock edge of `clk` stands for one bus subcycle. A high `sync` sampled at an edge starts a new instruction cycle. The next three subcycles carry the low address nibble, the high address nibble and a chip number. A separate command line, `cm_rom`, qualifies the chip number.

When the chip number matches the block's fixed strap `CHIP_ID` while `cm_rom` is high, the block returns the addressed byte in the following two subcycles. The high nibble comes first. At every other time the block leaves the bus undriven. Up to sixteen such blocks can share one bus and one command line, each with a different strap.

The sequencer walks through nine named states:

- IDLE: waiting for `sync`.
- ADR_LO: the low address nibble is on the bus.
- ADR_HI: the high address nibble is on the bus.
- CHIP: the chip number is on the bus.
- DAT_HI: the block returns the high data nibble.
- DAT_LO: the block returns the low data nibble.
- EXE1, EXE2, EXE3: three trailing subcycles in which the block does nothing.

The transitions are as follows:

- ADR_LO→ADR_HI→CHIP→DAT_HI→DAT_LO→EXE1→EXE2→EXE3→IDLE.
- IDLE→IDLE.
- Any state→ADR_LO whenever `sync` is sampled high.
- Any state→IDLE on `poc`.

Top module: `nbrom_slave`

## Requirements
- R1: While `poc` is high at an edge, the next subcycle has `d_oe` low and the sequencer in IDLE with the select flag and address cleared; asserting `poc` during a data subcycle releases the bus from the following subcycle.
- R2: A high `sync` sampled at any edge moves the block to ADR_LO in the next subcycle, whatever state it was in.
- R3: The nibble present at the edge ending ADR_LO is stored as address bits 3:0, and the nibble at the edge ending ADR_HI as address bits 7:4.
- R4: The block is selected for the cycle only if, at the edge ending CHIP, `cm_rom` is high and `d_in` equals `CHIP_ID` (default 5).
- R5: When selected, the block puts address byte bits 7:4 on `d_out` during DAT_HI and bits 3:0 during DAT_LO, with `d_oe` high in both.
- R6: `d_oe` is high only in DAT_HI and DAT_LO of a selected cycle, and `d_out` is 0 whenever `d_oe` is low.
- R7: For address a below `PROG_LEN` (default 200), the stored byte is (a*`STEP`+`SEED`) mod 256, with defaults 37 and 11. Every address at or above `PROG_LEN` reads 0xFF.
- R8: Without a new `sync`, the block passes from EXE3 to IDLE and stays there with the bus released.
- R9: A `sync` sampled during DAT_HI ends the data return: the next subcycle is ADR_LO with `d_oe` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Subcycle clock; inputs are sampled and outputs change at its rising edge |
| poc | input | 1 | Power-on clear, active high, synchronous |
| sync | input | 1 | Instruction cycle marker; the next subcycle is ADR_LO |
| cm_rom | input | 1 | ROM command line, qualifies the chip number in CHIP |
| d_in | input | 4 | Bus nibble as seen by the block |
| d_out | output | 4 | Nibble the block places on the bus |
| d_oe | output | 1 | Bus driver enable; low means the pins float |

## Verification
Two events can meet in the same subcycle: a data return in DAT_HI, and a restart by `sync` or a clear by `poc`. The bench provokes this by fetching a selected byte and checking the high nibble in DAT_HI. It then raises `sync` (or `poc`) in that same subcycle. The case is judged correct only if the following subcycle shows the bus released instead of the low nibble, and if a restarted fetch then returns its own byte unaffected by the aborted one.

// File: rtl/nbrom_pkg.sv
package nbrom_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADR_LO,
        ST_ADR_HI,
        ST_CHIP,
        ST_DAT_HI,
        ST_DAT_LO,
        ST_EXE1,
        ST_EXE2,
        ST_EXE3
    } bus_state_t;

    // Programmed content: a linear sequence below len, blank (all ones) above.
    function automatic logic [7:0] rom_byte(input int a, input int len,
                                            input int step, input int seed);
        int v;
        if (a >= len) return 8'hFF;
        v = (a * step + seed) % 256;
        return v[7:0];
    endfunction

endpackage

// File: rtl/nbrom_seq.sv
module nbrom_seq
    import nbrom_pkg::*;
(
    input  logic       clk,
    input  logic       poc,
    input  logic       sync,
    output bus_state_t state,
    output logic       cap_lo,
    output logic       cap_hi,
    output logic       cap_chip,
    output logic       drv_hi,
    output logic       drv_lo
);

    bus_state_t nxt;

    always_comb begin
        nxt = ST_IDLE;
        if (sync) begin
            nxt = ST_ADR_LO;
        end else begin
            unique case (state)
                ST_IDLE:   nxt = ST_IDLE;
                ST_ADR_LO: nxt = ST_ADR_HI;
                ST_ADR_HI: nxt = ST_CHIP;
                ST_CHIP:   nxt = ST_DAT_HI;
                ST_DAT_HI: nxt = ST_DAT_LO;
                ST_DAT_LO: nxt = ST_EXE1;
                ST_EXE1:   nxt = ST_EXE2;
                ST_EXE2:   nxt = ST_EXE3;
                ST_EXE3:   nxt = ST_IDLE;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (poc) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        cap_lo   = 1'b0;
        cap_hi   = 1'b0;
        cap_chip = 1'b0;
        drv_hi   = 1'b0;
        drv_lo   = 1'b0;
        unique case (state)
            ST_ADR_LO: cap_lo   = 1'b1;
            ST_ADR_HI: cap_hi   = 1'b1;
            ST_CHIP:   cap_chip = 1'b1;
            ST_DAT_HI: drv_hi   = 1'b1;
            ST_DAT_LO: drv_lo   = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/nbrom_latch.sv
module nbrom_latch #(
    parameter int            NIB_W   = 4,
    parameter logic [3:0]    CHIP_ID = 4'd5,
    localparam int           ADDR_W  = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              poc,
    input  logic              sync,
    input  logic              cm_rom,
    input  logic [NIB_W-1:0]  d_in,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic              cap_chip,
    output logic [ADDR_W-1:0] addr,
    output logic              hit
);

    always_ff @(posedge clk) begin
        if (poc) begin
            addr <= '0;
            hit  <= 1'b0;
        end else begin
            if (cap_lo) addr[NIB_W-1:0]      <= d_in;
            if (cap_hi) addr[ADDR_W-1:NIB_W] <= d_in;
            if (cap_chip) hit <= cm_rom && (d_in == NIB_W'(CHIP_ID));
            if (sync)     hit <= 1'b0;
        end
    end

endmodule

// File: rtl/nbrom_array.sv
module nbrom_array
    import nbrom_pkg::*;
#(
    parameter int  ADDR_W   = 8,
    parameter int  PROG_LEN = 200,
    parameter int  STEP     = 37,
    parameter int  SEED     = 11,
    localparam int DEPTH    = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        data
);

    logic [7:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        assign cells[i] = rom_byte(i, PROG_LEN, STEP, SEED);
    end

    assign data = cells[addr];

endmodule

// File: rtl/nbrom_slave.sv
module nbrom_slave
    import nbrom_pkg::*;
#(
    parameter logic [3:0] CHIP_ID  = 4'd5,
    parameter int         PROG_LEN = 200,
    parameter int         STEP     = 37,
    parameter int         SEED     = 11,
    localparam int        NIB_W    = 4,
    localparam int        ADDR_W   = 2 * NIB_W
) (
    input  logic             clk,
    input  logic             poc,
    input  logic             sync,
    input  logic             cm_rom,
    input  logic [NIB_W-1:0] d_in,
    output logic [NIB_W-1:0] d_out,
    output logic             d_oe
);

    bus_state_t        state;
    logic              cap_lo, cap_hi, cap_chip, drv_hi, drv_lo;
    logic [ADDR_W-1:0] addr;
    logic              hit;
    logic [7:0]        rbyte;

    nbrom_seq u_seq (
        .clk(clk), .poc(poc), .sync(sync), .state(state),
        .cap_lo(cap_lo), .cap_hi(cap_hi), .cap_chip(cap_chip),
        .drv_hi(drv_hi), .drv_lo(drv_lo)
    );

    nbrom_latch #(.NIB_W(NIB_W), .CHIP_ID(CHIP_ID)) u_latch (
        .clk(clk), .poc(poc), .sync(sync), .cm_rom(cm_rom), .d_in(d_in),
        .cap_lo(cap_lo), .cap_hi(cap_hi), .cap_chip(cap_chip),
        .addr(addr), .hit(hit)
    );

    nbrom_array #(.ADDR_W(ADDR_W), .PROG_LEN(PROG_LEN), .STEP(STEP), .SEED(SEED)) u_array (
        .addr(addr), .data(rbyte)
    );

    always_comb begin
        d_oe  = hit && (drv_hi || drv_lo);
        d_out = '0;
        if (d_oe) d_out = drv_hi ? rbyte[7:4] : rbyte[3:0];
    end

endmodule

// File: rtl/nbrom_chk.sv
module nbrom_chk #(
    parameter logic [3:0] CHIP_ID = 4'd5
) (
    input logic       clk,
    input logic       poc,
    input logic       sync,
    input logic       cm_rom,
    input logic [3:0] d_in,
    input logic [3:0] d_out,
    input logic       d_oe
);

    p_clear_release_r1: assert property (@(posedge clk) poc |=> !d_oe);

    p_restart_release_r9: assert property (@(posedge clk) disable iff (poc)
        sync |=> !d_oe);

    p_select_strap_r4: assert property (@(posedge clk) disable iff (poc)
        $rose(d_oe) |-> ($past(cm_rom) && $past(d_in) == CHIP_ID));

    p_two_nibbles_r5: assert property (@(posedge clk) disable iff (poc)
        ($rose(d_oe) && !sync) |=> d_oe);

    p_drive_window_r6: assert property (@(posedge clk) disable iff (poc)
        (d_oe && $past(d_oe)) |=> !d_oe);

endmodule

bind nbrom_slave nbrom_chk #(.CHIP_ID(CHIP_ID)) u_chk (
    .clk(clk), .poc(poc), .sync(sync), .cm_rom(cm_rom),
    .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
);

// File: tb/sim_nbrom_slave.sv
module sim_nbrom_slave;

    logic       clk = 1'b0;
    logic       poc = 1'b1;
    logic       sync = 1'b0;
    logic       cm_rom = 1'b0;
    logic [3:0] d_in = 4'd0;
    logic [3:0] d_out;
    logic       d_oe;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    typedef struct {
        logic       oe;
        logic [3:0] nib;
        string      req;
    } exp_t;

    exp_t q[$];
    event smp;

    always #2.5 clk = ~clk;

    nbrom_slave u0 (
        .clk(clk), .poc(poc), .sync(sync), .cm_rom(cm_rom),
        .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
    );

    function automatic logic [7:0] ref_byte(input int a);
        if (a >= 200) return 8'hFF;
        return 8'((a * 37 + 11) % 256);
    endfunction

    task automatic check(input logic oe_e, input logic [3:0] nib_e, input string req);
        total++;
        if (d_oe !== oe_e || d_out !== nib_e) begin
            bad++;
            $display("FAIL %s: oe=%b out=%h expected oe=%b out=%h", req, d_oe, d_out, oe_e, nib_e);
        end
    endtask

    // monitor: pops an expected item at every sample strobe
    initial begin
        forever begin
            @(smp);
            if (q.size() == 0) begin
                total++; bad++;
                $display("FAIL scoreboard: oe=%b out=%h expected none", d_oe, d_out);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.oe, e.nib, e.req);
            end
        end
    end

    // driver: called at a falling edge, returns at a falling edge
    task automatic fetch(input int a, input logic [3:0] chip, input logic cmv, input bit abort);
        logic [7:0] b;
        bit         sel;
        exp_t       e;
        b   = ref_byte(a);
        sel = cmv && chip == 4'd5;
        e.oe = 1'b0; e.nib = 4'd0; e.req = "R2/R9 ADR_LO idle"; q.push_back(e);
        e.oe = sel; e.nib = sel ? b[7:4] : 4'd0; e.req = "R3/R4/R5/R7 DAT_HI"; q.push_back(e);
        if (!abort) begin
            e.oe = sel; e.nib = sel ? b[3:0] : 4'd0; e.req = "R3/R5/R7 DAT_LO"; q.push_back(e);
            e.oe = 1'b0; e.nib = 4'd0; e.req = "R6 EXE1"; q.push_back(e);
        end
        sync = 1'b1; d_in = 4'd0; cm_rom = 1'b0;
        @(posedge clk); @(negedge clk);
        -> smp;
        sync = 1'b0; d_in = 4'(a);
        @(posedge clk); @(negedge clk);
        d_in = 4'(a >> 4);
        @(posedge clk); @(negedge clk);
        d_in = chip; cm_rom = cmv;
        @(posedge clk); @(negedge clk);
        d_in = 4'd0; cm_rom = 1'b0;
        -> smp;
        if (abort) return;
        @(posedge clk); @(negedge clk);
        -> smp;
        @(posedge clk); @(negedge clk);
        -> smp;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                total++; bad++;
                $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1'b0, 4'd0, "R1 reset");
        poc = 1'b0;
        @(negedge clk);
        check(1'b0, 4'd0, "R1 after reset");

        fetch(0, 4'd5, 1'b1, 0);     // R7 first location
        fetch(8'hC7, 4'd5, 1'b1, 0); // R3 R7 last programmed
        fetch(200, 4'd5, 1'b1, 0);   // R7 blank
        fetch(255, 4'd5, 1'b1, 0);   // R7 blank top
        fetch(8'h3A, 4'd4, 1'b1, 0); // R4 other chip
        fetch(8'h3A, 4'd5, 1'b0, 0); // R4 no command
        fetch(8'h3A, 4'd13, 1'b1, 0);// R4 other chip
        fetch(8'h5C, 4'd5, 1'b1, 0); // R3 nibble order
        fetch(8'h81, 4'd5, 1'b1, 1); // R9 abort at DAT_HI
        fetch(8'h17, 4'd5, 1'b1, 0); // restart after abort

        // R8: no further sync
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check(1'b0, 4'd0, "R8 idle");
        end

        // R1: clear during data return
        fetch(8'h42, 4'd5, 1'b1, 1);
        poc = 1'b1;
        @(posedge clk); @(negedge clk);
        check(1'b0, 4'd0, "R1 clear mid-fetch");
        poc = 1'b0;
        @(posedge clk); @(negedge clk);
        check(1'b0, 4'd0, "R1 stays idle");
        fetch(8'h42, 4'd5, 1'b1, 0);

        @(negedge clk);
        if (q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard: left=%0d expected 0", q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule